// File: doc/BRIEF.md
# I2C Target with Filtered Sampling

This block is an I2C target that oversamples the SCL and SDA bus lines with a fast system clock. It takes part in standard-mode (100 kHz) and fast-mode (400 kHz) transfers. It answers to one 7-bit address, set by a parameter. After a match it either takes in or sends out any number of bytes, and a repeated START may switch direction inside one transaction. SCL is only an input, so the block never stretches the clock. The block never drives SDA high. It can only pull SDA to 0 or leave it released.

Both lines go through a four-sample edge filter before the transfer logic sees them. A STOP, a START or a repeated START seen on the filtered lines puts the transfer logic back to its start point from any state. After each filtered SCL fall, a short hold delay passes before SDA changes. A watchdog counter releases SDA and drops the transfer if the block has held the line low for too long.

The host side has no back-pressure. A received byte is shown with `rx_valid_o` for a fixed number of cycles, with no ready signal, so the host must take it in that window. For a read, `tx_req_o` pulses before every byte. The host must present `tx_data_i` before the following SCL fall, which is about half a bit period later.

Top module: `i2ct_target`

## Requirements
- R1: The block only ever pulls SDA low (`sda_pull_o` = 1 means drive 0). It leaves SDA released after reset, while idle, and whenever it is not acknowledging or sending a 0 bit. An input that does not read as 0 is taken as 1.
- R2: SCL and SDA are each filtered by a 4-sample shift register (newest sample in bit 0). A filtered rise is taken only on the pattern 0011 and a filtered fall only on 1100, so a spike one system clock wide changes nothing.
- R3: A START (SDA falls while SCL is high) restarts address reception from any state. This includes a repeated START with no STOP before it. A STOP (SDA rises while SCL is high) returns the block to idle from any state, including in the middle of a byte.
- R4: The first byte after a START carries the address in bits 7..1, MSB first. If it equals `DEV_ADDR`, the block pulls SDA low through the 9th clock. If it does not match, SDA stays released and the block ignores the bus until the next START or STOP.
- R5: In a write, data bits are shifted in MSB first on SCL rises. Each byte is acknowledged in the 9th clock. `rx_valid_o` is high for exactly `PULSE_CYC` cycles, with the byte on `rx_data_o`.
- R6: In a read, `tx_req_o` is high for `PULSE_CYC` cycles before every byte: once after the address matches, and again after each master ACK. `tx_data_i` is captured at the SCL fall that ends the 9th clock and is sent MSB first.
- R7: If the master answers a sent byte with NACK (SDA high in the 9th clock), the block sends nothing more and raises no further request until the next START or STOP.
- R8: `read_mode_o` holds bit 0 of the most recent matching address byte (1 = read). It is 0 after reset.
- R9: After each filtered SCL fall, `sda_pull_o` keeps its value for at least `HOLD_CYC` system clocks before it changes.
- R10: If `sda_pull_o` stays high for `TIMEOUT_CYC` consecutive cycles, the block releases SDA and goes idle. It then ignores the bus until the next START.
- R11: Any number of bytes may follow one address in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as read at the pad |
| sda_i | input | 1 | Bus data line as read at the pad |
| sda_pull_o | output | 1 | 1 = pad pulls SDA to 0, 0 = pad released |
| rx_valid_o | output | 1 | Received-byte strobe, `PULSE_CYC` cycles wide |
| rx_data_o | output | 8 | Last received byte |
| tx_req_o | output | 1 | Request for the next byte to send, `PULSE_CYC` cycles wide |
| tx_data_i | input | 8 | Byte to send, captured at the end of the 9th clock |
| read_mode_o | output | 1 | Direction bit of the current addressed transfer |

## Verification
At one SCL fall the block both ends its acknowledge and places the first bit of the next byte, which is loaded from `tx_data_i`. The bench provokes this by sending bytes whose MSB is 0, so the line must stay low across the two slots, and bytes whose MSB is 1, so the line must be released. It judges the result by the bits a master reads back. A second meeting point is the watchdog timeout against the hold delay that every SCL fall restarts. The bench stalls SCL low inside the acknowledge slot. It then checks that the line is released, and that the clocks that follow produce no acknowledge and no received byte until a fresh START.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_WAIT,
    ST_ACK_SLOT,
    ST_RX,
    ST_TX,
    ST_TX_ACK,
    ST_IGNORE
  } xfer_st_e;

  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } line_ev_t;

endpackage

// File: rtl/i2ct_glitch_filter.sv
module i2ct_glitch_filter
  import i2ct_pkg::*;
#(
  parameter int FILT_W = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     raw_i,
  output line_ev_t ev_o
);

  localparam int HALF = FILT_W / 2;
  localparam logic [FILT_W-1:0] RISE_PAT = FILT_W'((1 << HALF) - 1);
  localparam logic [FILT_W-1:0] FALL_PAT = ~RISE_PAT;

  logic [FILT_W-1:0] sr_q;
  logic              lvl_q;
  logic              rise, fall;

  assign rise = (sr_q == RISE_PAT);
  assign fall = (sr_q == FALL_PAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '1;
      lvl_q <= 1'b1;
    end else begin
      sr_q <= {sr_q[FILT_W-2:0], raw_i};
      if (rise)      lvl_q <= 1'b1;
      else if (fall) lvl_q <= 1'b0;
    end
  end

  assign ev_o = '{lvl: lvl_q, rise: rise, fall: fall};

  // R2
  glitch_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lvl_q) |-> ($past(raw_i, 2) && $past(raw_i, 3)));
  // R2
  glitch_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lvl_q) |-> (!$past(raw_i, 2) && !$past(raw_i, 3)));

endmodule

// File: rtl/i2ct_sda_drive.sv
module i2ct_sda_drive #(
  parameter int HOLD_CYC    = 3,
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_fall_i,
  input  logic want_low_i,
  output logic pull_o,
  output logic abort_o
);

  localparam int HW = $clog2(HOLD_CYC + 2);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  logic [HW-1:0] hcnt_q;
  logic [TW-1:0] tcnt_q;
  logic          pull_q, abort_q, to_hit;

  assign to_hit = pull_q && (tcnt_q == TW'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q  <= '0;
      tcnt_q  <= '0;
      pull_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      abort_q <= to_hit;
      if (!pull_q || to_hit) tcnt_q <= '0;
      else                   tcnt_q <= tcnt_q + 1'b1;

      if (scl_fall_i)         hcnt_q <= HW'(HOLD_CYC);
      else if (hcnt_q != '0)  hcnt_q <= hcnt_q - 1'b1;

      if (to_hit)                                  pull_q <= 1'b0;
      else if (!scl_fall_i && hcnt_q == '0 && !abort_q) pull_q <= want_low_i;
    end
  end

  assign pull_o  = pull_q;
  assign abort_o = abort_q;

  logic [TW:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (pull_q) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  // R10
  pull_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(run_q) <= TIMEOUT_CYC);
  // R9
  hold_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_fall_i && !to_hit && HOLD_CYC > 0) |=> $stable(pull_o));

endmodule

// File: rtl/i2ct_xfer_fsm.sv
module i2ct_xfer_fsm
  import i2ct_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h3A,
  parameter int         PULSE_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  line_ev_t   scl_i,
  input  line_ev_t   sda_i,
  input  logic       abort_i,
  input  logic [7:0] tx_data_i,
  output logic       want_low_o,
  output logic       rx_valid_o,
  output logic [7:0] rx_data_o,
  output logic       tx_req_o,
  output logic       read_mode_o
);

  localparam int PW = $clog2(PULSE_CYC + 1);

  xfer_st_e      st_q;
  logic [2:0]    bit_q;
  logic [7:0]    sh_q, rxd_q;
  logic          want_q, rw_q, rmode_q;
  logic [PW-1:0] rxc_q, txc_q;
  logic          start_ev, stop_ev;

  assign start_ev = sda_i.fall && scl_i.lvl;
  assign stop_ev  = sda_i.rise && scl_i.lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      bit_q   <= '0;
      sh_q    <= '0;
      rxd_q   <= '0;
      want_q  <= 1'b0;
      rw_q    <= 1'b0;
      rmode_q <= 1'b0;
      rxc_q   <= '0;
      txc_q   <= '0;
    end else begin
      if (rxc_q != '0) rxc_q <= rxc_q - 1'b1;
      if (txc_q != '0) txc_q <= txc_q - 1'b1;
      if (start_ev) begin
        st_q   <= ST_ADDR;
        bit_q  <= '0;
        want_q <= 1'b0;
      end else if (stop_ev || abort_i) begin
        st_q   <= ST_IDLE;
        want_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR, ST_RX: if (scl_i.rise) begin
            sh_q  <= {sh_q[6:0], sda_i.lvl};
            bit_q <= bit_q + 3'd1;
            if (bit_q == 3'd7) begin
              if (st_q == ST_RX) begin
                rxd_q <= {sh_q[6:0], sda_i.lvl};
                rxc_q <= PW'(PULSE_CYC);
                st_q  <= ST_ACK_WAIT;
              end else if (sh_q[6:0] == DEV_ADDR) begin
                rw_q    <= sda_i.lvl;
                rmode_q <= sda_i.lvl;
                if (sda_i.lvl) txc_q <= PW'(PULSE_CYC);
                st_q    <= ST_ACK_WAIT;
              end else begin
                st_q <= ST_IGNORE;
              end
            end
          end
          ST_ACK_WAIT: if (scl_i.fall) begin
            want_q <= 1'b1;
            st_q   <= ST_ACK_SLOT;
          end
          ST_ACK_SLOT: if (scl_i.fall) begin
            bit_q <= '0;
            if (rw_q) begin
              sh_q   <= tx_data_i;
              want_q <= ~tx_data_i[7];
              st_q   <= ST_TX;
            end else begin
              want_q <= 1'b0;
              st_q   <= ST_RX;
            end
          end
          ST_TX: if (scl_i.fall) begin
            if (bit_q == 3'd7) begin
              want_q <= 1'b0;
              st_q   <= ST_TX_ACK;
            end else begin
              want_q <= ~sh_q[6];
              sh_q   <= {sh_q[6:0], 1'b0};
              bit_q  <= bit_q + 3'd1;
            end
          end
          ST_TX_ACK: if (scl_i.rise) begin
            if (!sda_i.lvl) begin
              txc_q <= PW'(PULSE_CYC);
              st_q  <= ST_ACK_SLOT;
            end else begin
              st_q <= ST_IGNORE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign want_low_o  = want_q;
  assign rx_valid_o  = (rxc_q != '0);
  assign rx_data_o   = rxd_q;
  assign tx_req_o    = (txc_q != '0);
  assign read_mode_o = rmode_q;

  // R3
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (st_q == ST_ADDR));
  // R3
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ev && !start_ev) |=> (st_q == ST_IDLE));
  // R4
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IGNORE) |-> !want_low_o);
  // R5
  rx_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid_o) |-> !read_mode_o);
  // R8
  tx_req_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_req_o) |-> read_mode_o);

endmodule

// File: rtl/i2ct_target.sv
module i2ct_target
  import i2ct_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h3A,
  parameter int         FILT_W      = 4,
  parameter int         HOLD_CYC    = 3,
  parameter int         TIMEOUT_CYC = 1000,
  parameter int         PULSE_CYC   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  output logic       rx_valid_o,
  output logic [7:0] rx_data_o,
  output logic       tx_req_o,
  input  logic [7:0] tx_data_i,
  output logic       read_mode_o
);

  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw;
  line_ev_t           ev [N_LINES];
  logic               want_low, abort;

  assign raw[0] = (scl_i === 1'b0) ? 1'b0 : 1'b1;
  assign raw[1] = (sda_i === 1'b0) ? 1'b0 : 1'b1;

  for (genvar g = 0; g < N_LINES; g++) begin : g_filt
    i2ct_glitch_filter #(.FILT_W(FILT_W)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .raw_i(raw[g]),
      .ev_o (ev[g])
    );
  end

  i2ct_xfer_fsm #(.DEV_ADDR(DEV_ADDR), .PULSE_CYC(PULSE_CYC)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (ev[0]),
    .sda_i      (ev[1]),
    .abort_i    (abort),
    .tx_data_i  (tx_data_i),
    .want_low_o (want_low),
    .rx_valid_o (rx_valid_o),
    .rx_data_o  (rx_data_o),
    .tx_req_o   (tx_req_o),
    .read_mode_o(read_mode_o)
  );

  i2ct_sda_drive #(.HOLD_CYC(HOLD_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_drv (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_fall_i(ev[0].fall),
    .want_low_i(want_low),
    .pull_o    (sda_pull_o),
    .abort_o   (abort)
  );

endmodule

// File: tb/i2ct_target_tb.sv
module i2ct_target_tb_top;

  localparam logic [6:0] ADDR = 7'h3A;
  localparam int HOLD = 3;
  localparam int TOUT = 1000;
  localparam int PW   = 4;
  localparam int Q    = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull, rx_valid, tx_req, read_mode;
  logic [7:0] rx_data, tx_data = 8'h00;
  logic sda_line;

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  i2ct_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .rx_valid_o(rx_valid), .rx_data_o(rx_data),
    .tx_req_o(tx_req), .tx_data_i(tx_data), .read_mode_o(read_mode)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] rx_log [32];
  logic [7:0] tx_src [8];
  int rx_n = 0, tx_n = 0, tx_idx = 0;
  int rx_run = 0, tx_run = 0, last_rx_w = 0, last_tx_w = 0;
  bit rx_prev = 0, tx_prev = 0, pull_seen = 0;

  always @(negedge clk) begin
    if (rx_valid && !rx_prev) begin rx_log[rx_n[4:0]] = rx_data; rx_n++; end
    if (rx_valid) rx_run++; else if (rx_prev) begin last_rx_w = rx_run; rx_run = 0; end
    if (tx_req && !tx_prev) begin tx_data = tx_src[tx_idx[2:0]]; tx_idx++; tx_n++; end
    if (tx_req) tx_run++; else if (tx_prev) begin last_tx_w = tx_run; tx_run = 0; end
    if (sda_pull) pull_seen = 1;
    rx_prev = rx_valid;
    tx_prev = tx_req;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic m_start();
    sda_m = 1; wq(Q); scl_m = 1; wq(Q); sda_m = 0; wq(Q); scl_m = 0; wq(Q);
  endtask
  task automatic m_stop();
    sda_m = 0; wq(Q); scl_m = 1; wq(Q); sda_m = 1; wq(Q);
  endtask
  task automatic m_bit_w(input bit b);
    sda_m = b; wq(Q); scl_m = 1; wq(2*Q); scl_m = 0; wq(Q);
  endtask
  task automatic m_bit_r(output bit b);
    sda_m = 1; wq(Q); scl_m = 1; wq(Q); b = sda_line; wq(Q); scl_m = 0; wq(Q);
  endtask
  task automatic m_wbyte(input logic [7:0] d, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) m_bit_w(d[i]);
    m_bit_r(b);
    ack = ~b;
  endtask
  task automatic m_rbyte(input bit ack, output logic [7:0] d);
    bit b;
    for (int i = 7; i >= 0; i--) begin m_bit_r(b); d[i] = b; end
    m_bit_w(~ack);
  endtask
  task automatic clr();
    rx_n = 0; tx_n = 0; tx_idx = 0; pull_seen = 0;
  endtask

  task automatic t_reset();
    chk(sda_pull == 0, "R1 released after reset", int'(sda_pull), 0);
    chk(rx_valid == 0 && tx_req == 0, "R5 R6 strobes low after reset", int'({rx_valid, tx_req}), 0);
    chk(read_mode == 0, "R8 read_mode after reset", int'(read_mode), 0);
  endtask

  task automatic t_write();
    bit a;
    logic [7:0] d [3] = '{8'hA5, 8'h3C, 8'h00};
    clr();
    m_start();
    m_wbyte({ADDR, 1'b0}, a);
    chk(a, "R4 address ack", int'(a), 1);
    chk(read_mode == 0, "R8 write mode", int'(read_mode), 0);
    for (int i = 0; i < 3; i++) begin
      m_wbyte(d[i], a);
      chk(a, "R5 data ack", int'(a), 1);
    end
    m_stop();
    chk(rx_n == 3, "R11 byte count", rx_n, 3);
    for (int i = 0; i < 3; i++) chk(rx_log[i] == d[i], "R5 rx byte", int'(rx_log[i]), int'(d[i]));
    chk(last_rx_w == PW, "R5 strobe width", last_rx_w, PW);
    chk(sda_pull == 0, "R1 released after stop", int'(sda_pull), 0);
  endtask

  task automatic t_wrong_addr();
    bit a;
    clr();
    m_start();
    m_wbyte({ADDR ^ 7'h01, 1'b0}, a);
    chk(!a, "R4 no ack on mismatch", int'(a), 0);
    m_wbyte(8'h55, a);
    chk(!a, "R4 ignored data no ack", int'(a), 0);
    m_stop();
    chk(rx_n == 0, "R4 no rx after mismatch", rx_n, 0);
    chk(pull_seen == 0, "R4 line untouched", int'(pull_seen), 0);
  endtask

  task automatic t_read();
    bit a;
    logic [7:0] d;
    logic [7:0] exp [3] = '{8'h5A, 8'hC3, 8'h81};
    clr();
    for (int i = 0; i < 3; i++) tx_src[i] = exp[i];
    m_start();
    m_wbyte({ADDR, 1'b1}, a);
    chk(a, "R4 read address ack", int'(a), 1);
    chk(read_mode == 1, "R8 read mode", int'(read_mode), 1);
    for (int i = 0; i < 3; i++) begin
      m_rbyte(i < 2, d);
      chk(d == exp[i], "R6 tx byte", int'(d), int'(exp[i]));
    end
    chk(tx_n == 3, "R6 request per byte", tx_n, 3);
    chk(last_tx_w == PW, "R6 request width", last_tx_w, PW);
    pull_seen = 0;
    m_rbyte(1'b0, d);
    chk(d == 8'hFF, "R7 silent after nack", int'(d), 8'hFF);
    chk(pull_seen == 0 && tx_n == 3, "R7 no drive no request", int'(pull_seen) * 16 + tx_n, 3);
    m_stop();
  endtask

  task automatic t_rep_start();
    bit a;
    logic [7:0] d;
    clr();
    tx_src[0] = 8'h7E;
    m_start();
    m_wbyte({ADDR, 1'b0}, a);
    m_wbyte(8'h11, a);
    chk(read_mode == 0, "R8 write before restart", int'(read_mode), 0);
    m_start();
    m_wbyte({ADDR, 1'b1}, a);
    chk(a, "R3 ack after repeated start", int'(a), 1);
    chk(read_mode == 1, "R8 read after restart", int'(read_mode), 1);
    m_rbyte(1'b0, d);
    chk(d == 8'h7E, "R3 read after restart", int'(d), 8'h7E);
    m_stop();
    chk(rx_n == 1 && rx_log[0] == 8'h11, "R3 write part", int'(rx_log[0]), 8'h11);
  endtask

  task automatic t_stop_mid();
    bit a;
    clr();
    m_start();
    m_wbyte({ADDR, 1'b0}, a);
    for (int i = 0; i < 4; i++) m_bit_w(1'b1);
    m_stop();
    m_start();
    m_wbyte({ADDR, 1'b0}, a);
    chk(a, "R3 ack after mid-byte stop", int'(a), 1);
    m_wbyte(8'h96, a);
    m_stop();
    chk(rx_n == 1 && rx_log[0] == 8'h96, "R3 aligned after stop", int'(rx_log[0]), 8'h96);
  endtask

  task automatic t_glitch();
    bit a;
    logic [7:0] v = 8'hA5;
    clr();
    m_start();
    m_wbyte({ADDR, 1'b0}, a);
    for (int i = 7; i >= 0; i--) begin
      sda_m = v[i]; wq(Q); scl_m = 1; wq(Q);
      if (i == 4) begin scl_m = 0; wq(1); scl_m = 1; end
      if (i == 2) begin sda_m = 0; wq(1); sda_m = 1; end
      wq(Q); scl_m = 0; wq(Q);
    end
    m_bit_r(a);
    chk(a == 0, "R2 ack despite spikes", int'(a), 0);
    m_stop();
    chk(rx_n == 1 && rx_log[0] == v, "R2 byte despite spikes", int'(rx_log[0]), int'(v));
  endtask

  task automatic t_hold();
    bit a;
    int d = 0;
    logic [7:0] ab = {ADDR, 1'b0};
    m_start();
    for (int i = 7; i >= 1; i--) m_bit_w(ab[i]);
    sda_m = 0; wq(Q); scl_m = 1; wq(2*Q); scl_m = 0;
    while (!sda_pull && d < 40) begin @(negedge clk); d++; end
    chk(d > HOLD && d <= HOLD + 8, "R9 hold before ack", d, HOLD + 4);
    wq(Q - d);
    m_bit_r(a);
    chk(a == 0, "R9 ack after hold", int'(a), 0);
    m_stop();
  endtask

  task automatic t_timeout();
    bit a;
    logic [7:0] ab = {ADDR, 1'b0};
    clr();
    m_start();
    for (int i = 7; i >= 0; i--) m_bit_w(ab[i]);
    sda_m = 1;
    wq(TOUT + 200);
    chk(pull_seen == 1, "R10 ack was driven", int'(pull_seen), 1);
    chk(sda_pull == 0, "R10 released by timeout", int'(sda_pull), 0);
    pull_seen = 0;
    scl_m = 1; wq(2*Q); scl_m = 0; wq(Q);
    m_wbyte(8'hE7, a);
    chk(!a && rx_n == 0, "R10 idle after timeout", int'(a) + rx_n, 0);
    m_stop();
    m_start();
    m_wbyte({ADDR, 1'b0}, a);
    chk(a, "R10 recovers on next start", int'(a), 1);
    m_stop();
  endtask

  initial begin
    wq(5);
    rst_n = 1;
    wq(10);
    t_reset();
    t_write();
    t_wrong_addr();
    t_read();
    t_rep_start();
    t_stop_mid();
    t_glitch();
    t_hold();
    t_timeout();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule